// File: doc/BRIEF.md
# SPI Serial Memory Target Emulator

This block behaves as a small byte-addressed nonvolatile memory that answers as a target on an SPI bus in mode 0. The controller lowers chip select and sends a one-byte opcode. Depending on the opcode, address bytes and data bytes follow or data bytes come back. The block handles a write-enable latch, reading and writing the status byte, streaming array reads with auto-increment, and page writes. After a page write it reports busy for a programmable number of system clocks. The storage is an internal register array, so the block can stand in for a real memory device in a system model or on a test chip.

The SPI pins are sampled into the block's system clock domain, which must run several times faster than SCK. Three parameters fix the address layout: the number of address bytes (1, 2 or 3), the page size, and a nine-bit mode. In nine-bit mode one address byte is sent, and opcode bit 3 carries address bit 8. MISO is driven through a separate output-enable, which is low whenever chip select is high.

Top module: `spi_mem_target`

## Requirements
- R1: After reset, MISO output-enable is low, the status byte reads 0x00 and the write-enable latch is clear.
- R2: The MISO output-enable is high only while chip select is low.
- R3: Opcode 0x06 sets the write-enable latch and opcode 0x04 clears it. The latch is status bit 1, and busy is status bit 0.
- R4: A data write (0x02) or status write (0x01) sent while the write-enable latch is clear changes no stored byte and does not start busy.
- R5: Opcode 0x03, followed by the address sent most-significant byte first, returns the byte at that address and then consecutive bytes for as long as chip select stays low. Bits are sampled on rising SCK, shifted out on falling SCK, and sent MSB first.
- R6: Opcode 0x02 stores each complete data byte at the current address. The address increments within the page, so a write past the last byte of a page continues at the first byte of the same page.
- R7: When chip select rises after a write that stored at least one byte, busy is set for BUSY_CYCLES system clocks. Busy then clears, and the write-enable latch clears with it.
- R8: While busy, only the status read (0x05) is honoured. Any other command changes no state and returns 0x00 on MISO.
- R9: In nine-bit mode, opcode bit 3 (0x0B read, 0x0A write) gives address bit 8 above the single address byte. A streaming read carries over from 0x0FF to 0x100.
- R10: Opcode 0x01 with the latch set stores data bits 2, 3 and 7 into status bits 2, 3 and 7. The other status bits are not writable, and the latch stays set.
- R11: A streaming read past the last array byte continues at address 0.
- R12: A command that stores no data byte, such as 0x06 alone, does not set busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than SCK |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck_i | input | 1 | SPI serial clock |
| spi_cs_n_i | input | 1 | SPI chip select, active low |
| spi_mosi_i | input | 1 | Data from controller |
| spi_miso_o | output | 1 | Data to controller |
| spi_miso_oe_o | output | 1 | MISO output enable |

## Verification
A wrong bit counter or phase shows up on the very next returned byte as a shifted or stale value, so one streaming read exposes it within eight SCK periods. A wrong write address or a broken page wrap appears only when the byte is read back. For that reason, every stored pattern is read again after busy ends, including addresses on both sides of bit 8 and at the page and array ends. An error in the busy counter or the latch shows in the next status read: busy is checked at once after a write and again after the interval, and a command that should be ignored while busy is checked by reading back the target afterwards.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;
    localparam logic [7:0] OP_LATCH_SET = 8'h06;
    localparam logic [7:0] OP_LATCH_CLR = 8'h04;
    localparam logic [7:0] OP_STAT_GET  = 8'h05;
    localparam logic [7:0] OP_STAT_PUT  = 8'h01;
    localparam logic [7:0] OP_ARR_GET   = 8'h03;
    localparam logic [7:0] OP_ARR_PUT   = 8'h02;
    localparam logic [7:0] OP_HI_MASK   = 8'hF7;

    typedef enum logic [2:0] {
        PH_OPC, PH_ADR, PH_RD, PH_WR, PH_STR, PH_STW, PH_SKIP
    } phase_e;
endpackage

// File: rtl/spi_mem_sync.sv
module spi_mem_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    input  logic mosi,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_n_s,
    output logic cs_rise,
    output logic mosi_s
);
    logic [STAGES:0] sck_p, cs_p, mosi_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_p  <= '0;
            cs_p   <= '1;
            mosi_p <= '0;
        end else begin
            sck_p  <= {sck_p[STAGES-1:0], sck};
            cs_p   <= {cs_p[STAGES-1:0], cs_n};
            mosi_p <= {mosi_p[STAGES-1:0], mosi};
        end
    end

    assign sck_rise = sck_p[STAGES-1] & ~sck_p[STAGES];
    assign sck_fall = ~sck_p[STAGES-1] & sck_p[STAGES];
    assign cs_n_s   = cs_p[STAGES-1];
    assign cs_rise  = cs_p[STAGES-1] & ~cs_p[STAGES];
    assign mosi_s   = mosi_p[STAGES-1];
endmodule

// File: rtl/spi_mem_array.sv
module spi_mem_array #(
    parameter int DEPTH = 512,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/spi_mem_target.sv
module spi_mem_target
    import spi_mem_pkg::*;
#(
    parameter int ADDR_BYTES  = 1,
    parameter bit NINE_BIT    = 1'b1,
    parameter int MEM_BYTES   = 512,
    parameter int PAGE_BYTES  = 16,
    parameter int BUSY_CYCLES = 3000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_sck_i,
    input  logic spi_cs_n_i,
    input  logic spi_mosi_i,
    output logic spi_miso_o,
    output logic spi_miso_oe_o
);
    localparam int AW  = $clog2(MEM_BYTES);
    localparam int PW  = $clog2(PAGE_BYTES);
    localparam int BCW = $clog2(BUSY_CYCLES + 1);
    localparam int ACW = $clog2(ADDR_BYTES + 1);

    typedef struct packed {
        phase_e         phase;
        logic [2:0]     bit_cnt;
        logic [7:0]     rx;
        logic [7:0]     tx;
        logic [ACW-1:0] abytes;
        logic [AW-1:0]  addr;
        logic           rd_mode;
        logic           wel;
        logic           busy;
        logic [BCW-1:0] bcnt;
        logic           bp0;
        logic           bp1;
        logic           wpen;
        logic           wrote;
    } st_t;

    st_t st_d, st_q;

    logic          sck_rise, sck_fall, cs_n_s, cs_rise, mosi_s;
    logic          mem_we;
    logic [7:0]    rdata;
    logic [7:0]    rx_byte;
    logic [7:0]    status;
    logic [AW+7:0] acat;

    spi_mem_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .sck(spi_sck_i), .cs_n(spi_cs_n_i), .mosi(spi_mosi_i),
        .sck_rise(sck_rise), .sck_fall(sck_fall),
        .cs_n_s(cs_n_s), .cs_rise(cs_rise), .mosi_s(mosi_s)
    );

    spi_mem_array #(.DEPTH(MEM_BYTES), .AW(AW)) u_array (
        .clk(clk), .we(mem_we), .waddr(st_q.addr), .wdata(rx_byte),
        .raddr(st_q.addr), .rdata(rdata)
    );

    always_comb begin
        st_d    = st_q;
        mem_we  = 1'b0;
        rx_byte = {st_q.rx[6:0], mosi_s};
        status  = {st_q.wpen, 3'b000, st_q.bp1, st_q.bp0, st_q.wel, st_q.busy};
        acat    = {st_q.addr, rx_byte};

        // internal write timer
        if (st_q.busy) begin
            if (st_q.bcnt <= BCW'(1)) begin
                st_d.busy = 1'b0;
                st_d.wel  = 1'b0;
                st_d.bcnt = '0;
            end else begin
                st_d.bcnt = st_q.bcnt - 1'b1;
            end
        end

        if (cs_n_s) begin
            st_d.phase   = PH_OPC;
            st_d.bit_cnt = '0;
            st_d.tx      = '0;
        end else if (sck_rise) begin
            st_d.rx      = rx_byte;
            st_d.bit_cnt = st_q.bit_cnt + 1'b1;
            if (st_q.bit_cnt == 3'd7) begin
                unique case (st_q.phase)
                    PH_OPC: begin
                        st_d.phase   = PH_SKIP;
                        st_d.abytes  = '0;
                        st_d.addr    = '0;
                        st_d.addr[0] = NINE_BIT & rx_byte[3];
                        if (st_q.busy) begin
                            if (rx_byte == OP_STAT_GET) st_d.phase = PH_STR;
                        end else if (rx_byte == OP_LATCH_SET) begin
                            st_d.wel = 1'b1;
                        end else if (rx_byte == OP_LATCH_CLR) begin
                            st_d.wel = 1'b0;
                        end else if (rx_byte == OP_STAT_GET) begin
                            st_d.phase = PH_STR;
                        end else if (rx_byte == OP_STAT_PUT) begin
                            if (st_q.wel) st_d.phase = PH_STW;
                        end else if ((NINE_BIT ? (rx_byte & OP_HI_MASK) : rx_byte) == OP_ARR_GET) begin
                            st_d.phase   = PH_ADR;
                            st_d.rd_mode = 1'b1;
                        end else if ((NINE_BIT ? (rx_byte & OP_HI_MASK) : rx_byte) == OP_ARR_PUT) begin
                            if (st_q.wel) begin
                                st_d.phase   = PH_ADR;
                                st_d.rd_mode = 1'b0;
                            end
                        end
                    end
                    PH_ADR: begin
                        st_d.addr   = acat[AW-1:0];
                        st_d.abytes = st_q.abytes + 1'b1;
                        if (st_q.abytes == ACW'(ADDR_BYTES - 1))
                            st_d.phase = st_q.rd_mode ? PH_RD : PH_WR;
                    end
                    PH_RD: st_d.addr = st_q.addr + 1'b1;
                    PH_WR: begin
                        mem_we               = 1'b1;
                        st_d.wrote           = 1'b1;
                        st_d.addr[PW-1:0]    = st_q.addr[PW-1:0] + 1'b1;
                    end
                    PH_STW: begin
                        st_d.bp0   = rx_byte[2];
                        st_d.bp1   = rx_byte[3];
                        st_d.wpen  = rx_byte[7];
                        st_d.phase = PH_SKIP;
                    end
                    default: ;
                endcase
            end
        end else if (sck_fall) begin
            if ((st_q.phase == PH_RD || st_q.phase == PH_STR) && st_q.bit_cnt == 3'd0)
                st_d.tx = (st_q.phase == PH_RD) ? rdata : status;
            else
                st_d.tx = {st_q.tx[6:0], 1'b0};
        end

        if (cs_rise) begin
            if (st_q.wrote) begin
                st_d.busy = 1'b1;
                st_d.bcnt = BCW'(BUSY_CYCLES);
            end
            st_d.wrote = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.phase <= PH_OPC;
        end else begin
            st_q <= st_d;
        end
    end

    assign spi_miso_oe_o = ~cs_n_s;
    assign spi_miso_o    = ~cs_n_s & st_q.tx[7];
endmodule

// File: rtl/spi_mem_checker.sv
module spi_mem_checker
    import spi_mem_pkg::*;
#(
    parameter int AW = 9,
    parameter int PW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cs_rise,
    input logic          busy,
    input logic          wel,
    input logic          mem_we,
    input phase_e        phase,
    input logic [AW-1:0] addr
);
    p_store_needs_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (wel && !busy));

    p_busy_starts_at_cs_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cs_rise));

    p_latch_drops_with_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !wel);

    p_page_stays_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_WR && $past(phase) == PH_WR) |-> addr[AW-1:PW] == $past(addr[AW-1:PW]));

    p_busy_blocks_array_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (phase != PH_WR && phase != PH_RD && phase != PH_ADR));
endmodule

bind spi_mem_target spi_mem_checker #(.AW(AW), .PW(PW)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_rise(cs_rise), .busy(st_q.busy),
    .wel(st_q.wel), .mem_we(mem_we), .phase(st_q.phase), .addr(st_q.addr)
);

// File: tb/test_spi_mem_target.sv
module test_spi_mem_target;
    localparam int BUSY = 3000;
    localparam int HALF = 8;

    logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic miso, oe;
    int   n_cmp = 0, n_bad = 0;

    always #4 clk = ~clk;

    spi_mem_target #(.BUSY_CYCLES(BUSY)) i_spi_mem_target (
        .clk(clk), .rst_n(rst_n), .spi_sck_i(sck), .spi_cs_n_i(cs_n),
        .spi_mosi_i(mosi), .spi_miso_o(miso), .spi_miso_oe_o(oe)
    );

    // {address[8:0], data}
    localparam logic [16:0] VEC [8] = '{
        {9'h000, 8'h5A}, {9'h0FF, 8'hC3}, {9'h100, 8'h3C}, {9'h1FF, 8'hA5},
        {9'h155, 8'h11}, {9'h0AA, 8'hEE}, {9'h180, 8'h7E}, {9'h07F, 8'h81}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            mosi = tx[i];
            repeat (HALF) @(negedge clk);
            rx[i] = miso;
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
            sck = 1'b0;
        end
    endtask

    task automatic cs_lo;
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic cs_hi;
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (2 * HALF) @(negedge clk);
    endtask

    task automatic cmd1(input logic [7:0] op);
        logic [7:0] d;
        cs_lo; xfer(op, d); cs_hi;
    endtask

    task automatic cmd2(input logic [7:0] op, input logic [7:0] v);
        logic [7:0] d;
        cs_lo; xfer(op, d); xfer(v, d); cs_hi;
    endtask

    task automatic get_status(output logic [7:0] s);
        logic [7:0] d;
        cs_lo; xfer(8'h05, d); xfer(8'h00, s); cs_hi;
    endtask

    task automatic put_bytes(input int a, input int n, input logic [7:0] d0, input bit latch);
        logic [7:0] d;
        if (latch) cmd1(8'h06);
        cs_lo;
        xfer(8'h02 | (a[8] ? 8'h08 : 8'h00), d);
        xfer(a[7:0], d);
        for (int k = 0; k < n; k++) xfer(d0 + 8'(k), d);
        cs_hi;
    endtask

    task automatic get_one(input int a, output logic [7:0] v);
        logic [7:0] d;
        cs_lo;
        xfer(8'h03 | (a[8] ? 8'h08 : 8'h00), d);
        xfer(a[7:0], d);
        xfer(8'h00, v);
        cs_hi;
    endtask

    task automatic wait_idle;
        repeat (BUSY + 50) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] s, v, d;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1 reset state
        chk("R1 oe after reset", int'(oe), 0);
        get_status(s);
        chk("R1 status after reset", s, 8'h00);

        // R3 / R12 latch control, no busy without data
        cmd1(8'h06);
        get_status(s);
        chk("R3 R12 latch set, not busy", s, 8'h02);
        cmd1(8'h04);
        get_status(s);
        chk("R3 latch cleared", s, 8'h00);

        // R6 / R9 vector walk
        for (int i = 0; i < 8; i++) begin
            put_bytes(int'(VEC[i][16:8]), 1, VEC[i][7:0], 1'b1);
            wait_idle;
            get_one(int'(VEC[i][16:8]), v);
            chk("R6 R9 stored byte", v, VEC[i][7:0]);
        end

        // R9 stream over bit 8, R11 stream over array end
        cs_lo; xfer(8'h03, d); xfer(8'hFF, d); xfer(8'h00, v);
        chk("R9 read 0x0FF", v, 8'hC3);
        xfer(8'h00, v);
        chk("R9 read carries to 0x100", v, 8'h3C);
        cs_hi;
        cs_lo; xfer(8'h0B, d); xfer(8'hFF, d); xfer(8'h00, v);
        chk("R11 read 0x1FF", v, 8'hA5);
        xfer(8'h00, v);
        chk("R11 read wraps to 0x000", v, 8'h5A);
        cs_hi;

        // R7 busy, R8 ignored commands while busy
        put_bytes(32'h020, 4, 8'h40, 1'b1);
        get_status(s);
        chk("R7 busy with latch", s, 8'h03);
        put_bytes(32'h020, 1, 8'hFF, 1'b0);
        get_one(32'h020, v);
        chk("R8 read while busy gives 0", v, 8'h00);
        wait_idle;
        get_status(s);
        chk("R7 busy and latch clear", s, 8'h00);

        // R5 streaming read; R8 write while busy left no trace
        cs_lo; xfer(8'h03, d); xfer(8'h20, d);
        for (int k = 0; k < 4; k++) begin
            xfer(8'h00, v);
            chk("R5 R8 streamed byte", v, 8'h40 + 8'(k));
        end
        cs_hi;

        // R4 write without latch
        put_bytes(32'h021, 1, 8'h00, 1'b0);
        get_status(s);
        chk("R4 no busy without latch", s, 8'h00);
        get_one(32'h021, v);
        chk("R4 byte unchanged", v, 8'h41);

        // R6 page wrap
        put_bytes(32'h13E, 4, 8'h90, 1'b1);
        wait_idle;
        get_one(32'h130, v);
        chk("R6 wrap to page start", v, 8'h92);
        get_one(32'h131, v);
        chk("R6 wrap second byte", v, 8'h93);
        get_one(32'h13F, v);
        chk("R6 page end byte", v, 8'h91);

        // R10 status write
        cmd1(8'h06);
        cmd2(8'h01, 8'hFF);
        get_status(s);
        chk("R10 status bits written", s, 8'h8E);
        cmd1(8'h04);
        cmd2(8'h01, 8'h00);
        get_status(s);
        chk("R10 R4 status write without latch", s, 8'h8C);

        // R2 output enable tracks chip select
        cs_lo;
        chk("R2 oe with cs low", int'(oe), 1);
        xfer(8'h05, d);
        cs_hi;
        chk("R2 oe with cs high", int'(oe), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule